// File: doc/BRIEF.md
# ADC Conversion Sequencer with Shadowed Selection

This block is the digital control for a successive-approximation ADC. It counts ADC clock cycles for each conversion, strobes the sample-and-hold and each of the ten comparison steps, and collects the comparator decisions MSB first into a result word. It also owns the channel and reference selection. The CPU writes the selection into a holding register. The value driven to the analog mux copies that register only while no sampling window is open.

The sequencer runs on the system clock. An ADC clock tick input marks each ADC clock edge, and a phase input tells whether that edge is rising or falling. Conversions start on a rising tick and last 13 ADC cycles. The first conversion after the block is enabled lasts 25 ADC cycles. In free-running mode a new conversion follows each completed one without further writes. A selection written during a conversion applies from the next conversion.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the control readback, the selection readback, the mux and reference outputs, the result and both strobes are all zero.
- R2: Write address 0 loads the holding register: bits [3:0] are the channel and bits [5:4] are the reference. While no conversion is locked, the mux and reference outputs take the written value two system cycles after the write.
- R3: The mux and reference outputs freeze at the rising tick that starts a conversion. A selection written after that point does not reach them before the completion cycle. From the completion cycle on, they follow the holding register again.
- R4: Write address 1 is the control register: bit 7 is enable, bit 6 is start, bit 5 is free-run and bit 4 is the completion flag. A conversion starts on the first rising tick after the write cycle. A normal conversion raises the completion flag on the twelfth rising tick after its start tick.
- R5: The first conversion after enable goes from 0 to 1 is extended. It raises the completion flag on the 24th rising tick after its start tick, and its sample strobe follows the falling tick of ADC cycle 13.
- R6: Exactly one sample strobe follows the falling tick in ADC cycle 1 of a normal conversion. Exactly ten step strobes follow the falling ticks in the next ten cycles. Each strobe is one system cycle wide.
- R7: The comparator input is taken on each step strobe. The first decision becomes result bit 9 and the last becomes bit 0. The result updates at completion.
- R8: The start bit reads 1 while a conversion runs. It clears at completion when free-run is off.
- R9: Writing 1 to control bit 4 clears the completion flag. Writing 0 there leaves it unchanged.
- R10: With enable, free-run and start set, the next conversion starts on the rising tick after the completion cycle, so completions are 13 rising ticks apart. A selection written during one conversion drives the following conversion.
- R11: Writing enable as 0 aborts a running conversion. No completion follows, and start reads 0. A start written together with enable 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_tick_i | input | 1 | One-cycle pulse marking an ADC clock edge |
| adc_rise_i | input | 1 | Phase of the tick: 1 rising, 0 falling |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | 1 | 0 selection holding register, 1 control register |
| wr_data_i | input | 8 | CPU write data |
| cmp_i | input | 1 | Comparator decision |
| ctrl_o | output | 8 | Control readback {enable, start, free-run, flag, 4'b0} |
| sel_o | output | 8 | Holding register readback, zero padded |
| mux_o | output | 4 | Effective channel select |
| ref_o | output | 2 | Effective reference select |
| sh_o | output | 1 | Sample-and-hold strobe |
| step_o | output | 1 | Compare-step strobe |
| result_o | output | 10 | Conversion result |

## Verification
The hardest case is a selection write that lands inside a locked window. Its effect must show only at the completion cycle, and in free-running mode only in the conversion that follows. The bench drives the ADC ticks itself and counts rising ticks. This lets it issue writes a few ADC cycles into each conversion and sample the mux outputs both inside the window and right after completion. The comparator bit is driven from a random target word, indexed by the strobes seen so far, so each result check also checks the bit order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned EN_B  = 7;
  localparam int unsigned ST_B  = 6;
  localparam int unsigned FR_B  = 5;
  localparam int unsigned DN_B  = 4;
  typedef struct packed {
    logic en;
    logic start;
    logic frun;
    logic done;
  } ctrl_t;
endpackage

// File: rtl/sel_shadow.sv
module sel_shadow #(
  parameter int unsigned MUX_W = 4,
  parameter int unsigned REF_W = 2,
  localparam int unsigned SEL_W = MUX_W + REF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wdata_i,
  input  logic             lock_i,
  output logic [SEL_W-1:0] tmp_o,
  output logic [SEL_W-1:0] eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_o <= '0;
      eff_o <= '0;
    end else begin
      if (wr_i) tmp_o <= wdata_i;
      if (!lock_i) eff_o <= tmp_o;
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned NORM_CYC = 13,
  parameter int unsigned EXT_CYC  = 25,
  parameter int unsigned NORM_SH  = 1,
  parameter int unsigned EXT_SH   = 13,
  parameter int unsigned STEPS    = 10,
  localparam int unsigned CYC_W   = $clog2(EXT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic go_i,
  input  logic ext_i,
  input  logic abort_i,
  output logic lock_o,
  output logic idle_o,
  output logic fin_o,
  output logic sh_o,
  output logic step_o
);
  logic [CYC_W-1:0] cyc_q, last_cyc, sh_cyc;
  logic act_q, ext_q;

  assign last_cyc = ext_q ? CYC_W'(EXT_CYC) : CYC_W'(NORM_CYC);
  assign sh_cyc   = ext_q ? CYC_W'(EXT_SH)  : CYC_W'(NORM_SH);
  assign lock_o   = act_q && (cyc_q != last_cyc);
  assign idle_o   = !act_q || (cyc_q == last_cyc);
  assign fin_o    = rise_i && act_q && !abort_i && (cyc_q == last_cyc - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cyc_q <= '0;
      ext_q <= 1'b0;
    end else if (abort_i) begin
      act_q <= 1'b0;
      cyc_q <= '0;
    end else if (rise_i) begin
      if (go_i) begin
        act_q <= 1'b1;
        cyc_q <= CYC_W'(1);
        ext_q <= ext_i;
      end else if (act_q) begin
        if (cyc_q == last_cyc) begin
          act_q <= 1'b0;
          cyc_q <= '0;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  // half-cycle events land on the falling tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_o   <= 1'b0;
      step_o <= 1'b0;
    end else begin
      sh_o   <= fall_i && act_q && !abort_i && (cyc_q == sh_cyc);
      step_o <= fall_i && act_q && !abort_i && (cyc_q > sh_cyc)
                && (cyc_q <= sh_cyc + CYC_W'(STEPS));
    end
  end
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             cmp_i,
  input  logic             load_i,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q    <= '0;
      result_o <= '0;
    end else begin
      if (clr_i)       sar_q <= '0;
      else if (step_i) sar_q <= {sar_q[RES_W-2:0], cmp_i};
      if (load_i) result_o <= sar_q;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned MUX_W    = 4,
  parameter int unsigned REF_W    = 2,
  parameter int unsigned RES_W    = 10,
  parameter int unsigned NORM_CYC = 13,
  parameter int unsigned EXT_CYC  = 25,
  parameter int unsigned NORM_SH  = 1,
  parameter int unsigned EXT_SH   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adc_tick_i,
  input  logic             adc_rise_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             cmp_i,
  output logic [DW-1:0]    ctrl_o,
  output logic [DW-1:0]    sel_o,
  output logic [MUX_W-1:0] mux_o,
  output logic [REF_W-1:0] ref_o,
  output logic             sh_o,
  output logic             step_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned SEL_W = MUX_W + REF_W;
  localparam int unsigned CNT_W = $clog2(RES_W + 1);

  ctrl_t ctl_q;
  logic first_q;
  logic wr_ctrl, wr_sel, rise, fall, go, lock, idle, fin;
  logic [SEL_W-1:0] sel_tmp, sel_eff;

  assign wr_ctrl = wr_en_i && wr_addr_i;
  assign wr_sel  = wr_en_i && !wr_addr_i;
  assign rise    = adc_tick_i && adc_rise_i;
  assign fall    = adc_tick_i && !adc_rise_i;
  assign go      = rise && ctl_q.en && ctl_q.start && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_q.en   <= wr_data_i[EN_B];
        ctl_q.frun <= wr_data_i[FR_B];
      end
      if (wr_ctrl && wr_data_i[EN_B] && !ctl_q.en) first_q <= 1'b1;
      else if (go)                                 first_q <= 1'b0;
      if (wr_ctrl && !wr_data_i[EN_B])             ctl_q.start <= 1'b0;
      else if (wr_ctrl && wr_data_i[ST_B])         ctl_q.start <= 1'b1;
      else if (fin && !ctl_q.frun)                 ctl_q.start <= 1'b0;
      if (fin)                                     ctl_q.done <= 1'b1;
      else if (wr_ctrl && wr_data_i[DN_B])         ctl_q.done <= 1'b0;
    end
  end

  sel_shadow #(.MUX_W(MUX_W), .REF_W(REF_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_sel),
    .wdata_i(wr_data_i[SEL_W-1:0]),
    .lock_i (lock),
    .tmp_o  (sel_tmp),
    .eff_o  (sel_eff)
  );

  conv_timer #(
    .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC),
    .NORM_SH (NORM_SH),  .EXT_SH (EXT_SH), .STEPS(RES_W)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .fall_i (fall),
    .go_i   (go),
    .ext_i  (first_q),
    .abort_i(!ctl_q.en),
    .lock_o (lock),
    .idle_o (idle),
    .fin_o  (fin),
    .sh_o   (sh_o),
    .step_o (step_o)
  );

  sar_shift #(.RES_W(RES_W)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go),
    .step_i  (step_o),
    .cmp_i   (cmp_i),
    .load_i  (fin),
    .result_o(result_o)
  );

  assign ctrl_o = {ctl_q, 4'b0000};
  assign sel_o  = DW'(sel_tmp);
  assign mux_o  = sel_eff[MUX_W-1:0];
  assign ref_o  = sel_eff[SEL_W-1:MUX_W];

  // step strobes since the last start, for the step-count check
  logic [CNT_W-1:0] chk_steps;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chk_steps <= '0;
    else if (go)     chk_steps <= '0;
    else if (step_o) chk_steps <= chk_steps + 1'b1;
  end

  a_r3_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock) |-> $stable(sel_eff));
  a_r8_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && ctl_q.en) |-> ctl_q.start);
  a_r4_flag_at_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> ctl_q.done);
  a_r6_ten_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |-> (chk_steps == CNT_W'(RES_W)));
  a_r6_strobe_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_o || step_o) |-> $past(lock));
endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, ph = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmp;
  logic [7:0] ctrl, sel;
  logic [3:0] mux;
  logic [1:0] refs;
  logic sh, step;
  logic [9:0] result;

  int checks = 0, fails = 0;
  int rise_cnt = 0, step_tot = 0, sh_cnt = 0, sh_rise = 0, step_base = 0;
  int kcnt = 0;
  logic [9:0] tgt = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .adc_tick_i(tick), .adc_rise_i(ph),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cmp_i(cmp),
    .ctrl_o(ctrl), .sel_o(sel), .mux_o(mux), .ref_o(refs),
    .sh_o(sh), .step_o(step), .result_o(result)
  );

  // ADC clock: a tick every 4 system cycles, alternating rise and fall
  initial forever begin
    @(negedge clk);
    kcnt++;
    tick = (kcnt % 4 == 0);
    ph   = ((kcnt / 4) % 2 == 0);
  end

  always @(posedge clk) begin
    if (tick && ph) rise_cnt <= rise_cnt + 1;
    if (step) step_tot <= step_tot + 1;
  end

  always @(negedge clk) if (sh) begin
    sh_cnt  = sh_cnt + 1;
    sh_rise = rise_cnt;
  end

  always_comb begin
    int rel;
    rel = step_tot - step_base;
    cmp = (rel >= 0 && rel < 10) ? tgt[9 - rel] : 1'b0;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(int t);
    while (rise_cnt < t) @(negedge clk);
  endtask

  // one conversion; optionally writes a new selection mid-window
  task automatic run_conv(bit ext, logic [9:0] t, bit chg);
    int r0, len, shc, sh0;
    logic [5:0] old_sel, nsel;
    old_sel = {refs, mux};
    nsel = 6'($urandom);
    len = ext ? 25 : 13;
    shc = ext ? 13 : 1;
    tgt = t;
    step_base = step_tot;
    sh0 = sh_cnt;
    wr(1'b1, 8'hC0);
    r0 = rise_cnt;
    wait_rise(r0 + 3);
    check("R8 start reads 1 while busy", int'(ctrl[6]), 1);
    if (chg) begin
      wr(1'b0, {2'b00, nsel});
      @(negedge clk);
      check("R3 mux frozen in window", int'({refs, mux}), int'(old_sel));
    end
    wait_rise(r0 + len - 1);
    check(ext ? "R5 no flag before 24 rises" : "R4 no flag before 12 rises", int'(ctrl[4]), 0);
    wait_rise(r0 + len);
    check(ext ? "R5 flag after 24 rises" : "R4 flag after 12 rises", int'(ctrl[4]), 1);
    check("R7 result msb first", int'(result), int'(t));
    check("R6 ten step strobes", step_tot - step_base, 10);
    check("R6 one sample strobe", sh_cnt - sh0, 1);
    check(ext ? "R5 sample in cycle 13" : "R6 sample in cycle 1", sh_rise, r0 + shc);
    check("R8 start clears at end", int'(ctrl[6]), 0);
    if (chg) begin
      @(negedge clk);
      check("R3 mux follows after end", int'({refs, mux}), int'(nsel));
    end
    wr(1'b1, 8'h90);
  endtask

  initial begin
    int r0;
    logic [5:0] s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 ctrl reset", int'(ctrl), 0);
    check("R1 sel reset", int'(sel), 0);
    check("R1 mux/ref reset", int'({refs, mux}), 0);
    check("R1 result reset", int'(result), 0);
    check("R1 strobes reset", int'({sh, step}), 0);
    rst_n = 1'b1;
    wr(1'b1, 8'h80);
    s = 6'h2B;
    wr(1'b0, {2'b00, s});
    check("R2 holding readback", int'(sel), int'(s));
    @(negedge clk);
    check("R2 mux follows idle", int'({refs, mux}), int'(s));

    run_conv(1'b1, 10'h2A5, 1'b1);

    // R9 flag clear behaviour
    wr(1'b1, 8'hC0);
    r0 = rise_cnt;
    wait_rise(r0 + 13);
    wr(1'b1, 8'h80);
    check("R9 write 0 keeps flag", int'(ctrl[4]), 1);
    wr(1'b1, 8'h90);
    check("R9 write 1 clears flag", int'(ctrl[4]), 0);

    for (int i = 0; i < 6; i++) run_conv(1'b0, 10'($urandom), 1'($urandom));
    run_conv(1'b0, 10'h3FF, 1'b0);
    run_conv(1'b0, 10'h000, 1'b1);

    // R10 free running
    tgt = 10'h155;
    step_base = step_tot;
    wr(1'b1, 8'hE0);
    r0 = rise_cnt;
    wait_rise(r0 + 4);
    s = 6'h19;
    wr(1'b0, {2'b00, s});
    wait_rise(r0 + 13);
    check("R10 first completion", int'(ctrl[4]), 1);
    check("R10 result", int'(result), 10'h155);
    wr(1'b1, 8'hB0);
    wait_rise(r0 + 15);
    check("R10 restarted, start held", int'(ctrl[6]), 1);
    check("R10 new selection used", int'({refs, mux}), int'(s));
    wait_rise(r0 + 25);
    check("R10 no flag before 13 rises", int'(ctrl[4]), 0);
    wait_rise(r0 + 26);
    check("R10 second completion", int'(ctrl[4]), 1);

    // R11 abort and ignored start
    wait_rise(r0 + 30);
    wr(1'b1, 8'h10);
    check("R11 start reads 0 after abort", int'(ctrl[6]), 0);
    wait_rise(r0 + 60);
    check("R11 no completion after abort", int'(ctrl[4]), 0);
    wr(1'b1, 8'h40);
    wait_rise(rise_cnt + 3);
    check("R11 start ignored when disabled", int'(ctrl), 0);

    wr(1'b1, 8'h80);
    run_conv(1'b1, 10'($urandom), 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule